// File: doc/BRIEF.md
# Carry-Skip Binary Adder

This block adds two unsigned binary operands and an input carry. It produces a sum of the same width and a carry-out, with no clock and no state. Each bit position first forms a generate signal and a propagate signal from its two operand bits. The carry then ripples through fixed-width sections. Each section also has a bypass path: when every bit in the section propagates, the section's incoming carry goes straight to its outgoing carry and does not wait for the ripple.

The adder is meant to sit in a datapath as the arithmetic core of an ALU or an address path. The operand width and the section width are parameters. By default the block adds 32-bit operands in 4-bit sections, which gives eight sections.

Top module: `csa_adder`

## Requirements
- R1: For every input, {carry_out, sum} equals the 33-bit value op_a + op_b + carry_in, treating both operands as unsigned.
- R2: Bit i has generate = op_a[i] AND op_b[i] and propagate = op_a[i] XOR op_b[i]. The two are never both 1. With op_a = 0xAAAAAAAA and op_b = 0x55555555, every bit propagates, so the sum is 0xFFFFFFFF with carry_out 0 when carry_in is 0.
- R3: Sum bit i is the XOR of propagate bit i and the carry entering bit i. With zero operands and carry_in 1, the sum is 0x00000001.
- R4: Inside a section, the carry into bit i+1 is generate(i) OR (propagate(i) AND carry into bit i). For example, 0x1 + 0x7 gives 0x8.
- R5: When all four propagate bits of a section are 1, the section's carry-out equals its carry-in. With op_a = 0xFFFFFFFF, op_b = 0 and carry_in 1, the sum is 0 and carry_out is 1.
- R6: The carry-out of the most significant section drives carry_out. For example, 0x80000000 + 0x80000000 gives sum 0 and carry_out 1.
- R7: With zero operands and carry_in 0, both the sum and carry_out are 0.
- R8: A carry produced in one section enters the section above it. For example, 0x0000000F + 0x1 gives 0x00000010, and 0x0FFFFFFF + 0x1 gives 0x10000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH (32) | First addend |
| op_b | input | WIDTH (32) | Second addend |
| carry_in | input | 1 | Incoming carry, weight 1 |
| sum | output | WIDTH (32) | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry leaving the top section |

## Verification
The bench builds two instances. The first uses the default 32-bit width with 4-bit sections. It receives directed corner cases: all-ones operands, carries crossing section boundaries, and fully propagating sections. It also receives several thousand random operand pairs, all compared with a behavioural addition. The second instance is 8 bits wide with 2-bit sections. It is small enough to sweep every operand pair with both carry-in values, so every combination of skip and ripple across four sections is exercised exhaustively.

// File: rtl/csa_pkg.sv
package csa_pkg;

    localparam int ADD_W  = 32;
    localparam int SECT_W = 4;

    typedef struct packed {
        logic gen;
        logic prop;
    } gp_bit_t;

    function automatic gp_bit_t make_gp(input logic a, input logic b);
        gp_bit_t r;
        r.gen  = a & b;
        r.prop = a ^ b;
        return r;
    endfunction

    function automatic logic ripple_step(input gp_bit_t x, input logic c);
        return x.gen | (x.prop & c);
    endfunction

endpackage

// File: rtl/csa_gp_gen.sv
module csa_gp_gen
    import csa_pkg::*;
#(
    parameter int WIDTH = ADD_W
) (
    input  logic [WIDTH-1:0]    op_a,
    input  logic [WIDTH-1:0]    op_b,
    output gp_bit_t [WIDTH-1:0] gp_o
);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            assign gp_o[i] = make_gp(op_a[i], op_b[i]);
        end
    endgenerate

    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            AST_GP_EXCLUSIVE: assert (!(gp_o[k].gen && gp_o[k].prop)) // R2
                else $error("generate and propagate both set at bit %0d", k);
        end
    end

endmodule

// File: rtl/csa_section.sv
module csa_section
    import csa_pkg::*;
#(
    parameter int SECT_W = csa_pkg::SECT_W
) (
    input  gp_bit_t [SECT_W-1:0] gp_i,
    input  logic                 c_i,
    output logic [SECT_W-1:0]    bit_c_o,
    output logic                 c_o
);

    logic [SECT_W:0] chain;
    logic            grp_prop;

    assign chain[0] = c_i;

    genvar j;
    generate
        for (j = 0; j < SECT_W; j++) begin : g_ripple
            assign chain[j+1] = ripple_step(gp_i[j], chain[j]);
        end
    endgenerate

    always_comb begin
        grp_prop = 1'b1;
        for (int k = 0; k < SECT_W; k++) begin
            grp_prop = grp_prop & gp_i[k].prop;
        end
    end

    assign bit_c_o = chain[SECT_W-1:0];
    assign c_o     = grp_prop ? c_i : chain[SECT_W];

    always_comb begin
        if (grp_prop) begin
            AST_SKIP_PASS: assert (c_o == c_i) // R5
                else $error("skip path did not forward carry");
        end
        if (grp_prop) begin
            AST_SKIP_AGREES: assert (chain[SECT_W] == c_i) // R4
                else $error("ripple disagrees with skip");
        end
    end

endmodule

// File: rtl/csa_sum.sv
module csa_sum
    import csa_pkg::*;
#(
    parameter int WIDTH = ADD_W
) (
    input  gp_bit_t [WIDTH-1:0] gp_i,
    input  logic [WIDTH-1:0]    bit_c_i,
    output logic [WIDTH-1:0]    sum_o
);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_sum
            assign sum_o[i] = gp_i[i].prop ^ bit_c_i[i];
        end
    endgenerate

    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            if (gp_i[k].gen) begin
                AST_GEN_SUM: assert (sum_o[k] == bit_c_i[k]) // R3
                    else $error("sum bit %0d wrong under generate", k);
            end
        end
    end

endmodule

// File: rtl/csa_adder.sv
module csa_adder
    import csa_pkg::*;
#(
    parameter int WIDTH  = ADD_W,
    parameter int SECT_W = csa_pkg::SECT_W
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    localparam int NSECT = WIDTH / SECT_W;

    gp_bit_t [WIDTH-1:0] gp;
    logic [WIDTH-1:0]    bit_c;
    logic [NSECT:0]      sect_c;

    csa_gp_gen #(.WIDTH(WIDTH)) u_gp (
        .op_a (op_a),
        .op_b (op_b),
        .gp_o (gp)
    );

    assign sect_c[0] = carry_in;

    genvar s;
    generate
        for (s = 0; s < NSECT; s++) begin : g_sect
            csa_section #(.SECT_W(SECT_W)) u_sec (
                .gp_i    (gp[s*SECT_W +: SECT_W]),
                .c_i     (sect_c[s]),
                .bit_c_o (bit_c[s*SECT_W +: SECT_W]),
                .c_o     (sect_c[s+1])
            );
        end
    endgenerate

    csa_sum #(.WIDTH(WIDTH)) u_sum (
        .gp_i    (gp),
        .bit_c_i (bit_c),
        .sum_o   (sum)
    );

    assign carry_out = sect_c[NSECT];

    always_comb begin
        AST_ADD_MATCH: assert ({carry_out, sum} ==
                               ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in})) // R1
            else $error("sum mismatch");
        if (op_a[WIDTH-1] && op_b[WIDTH-1]) begin
            AST_TOP_CARRY: assert (carry_out) // R6
                else $error("top generate lost");
        end
        if (op_a == '0 && op_b == '0) begin
            AST_ZERO_ADD: assert (!carry_out) // R7
                else $error("carry out on zero operands");
        end
    end

endmodule

// File: tb/csa_adder_tb.sv
module csa_adder_tb_top;

    localparam int W  = 32;
    localparam int NW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0]  a, b, s;
    logic          ci, co;
    logic [NW-1:0] na, nb, ns;
    logic          nci, nco;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    csa_adder #(.WIDTH(W), .SECT_W(4)) dut_i (
        .op_a(a), .op_b(b), .carry_in(ci), .sum(s), .carry_out(co)
    );

    csa_adder #(.WIDTH(NW), .SECT_W(2)) dut_narrow (
        .op_a(na), .op_b(nb), .carry_in(nci), .sum(ns), .carry_out(nco)
    );

    task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input string req, input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c, input logic [W:0] exp);
        @(negedge clk);
        a = x; b = y; ci = c;
        @(posedge clk);
        #1;
        check(req, {co, s}, exp);
    endtask

    function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    task automatic t_zero();            // R7
        apply("R7", '0, '0, 1'b0, 33'h0);
    endtask

    task automatic t_cin_only();        // R3
        apply("R3", '0, '0, 1'b1, 33'h0_0000_0001);
        apply("R3", 32'h0000_0100, 32'h0, 1'b1, 33'h0_0000_0101);
    endtask

    task automatic t_gp();              // R2
        apply("R2", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 33'h0_FFFF_FFFF);
        apply("R2", 32'h1234_5678, 32'h1234_5678, 1'b0, 33'h0_2468_ACF0);
    endtask

    task automatic t_ripple();          // R4
        apply("R4", 32'h1, 32'h7, 1'b0, 33'h0_0000_0008);
        apply("R4", 32'h3, 32'h0, 1'b1, 33'h0_0000_0004);
    endtask

    task automatic t_skip();            // R5
        apply("R5", 32'hFFFF_FFFF, 32'h0, 1'b1, 33'h1_0000_0000);
        apply("R5", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 33'h1_FFFF_FFFF);
        apply("R5", 32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b1, 33'h1_0000_0000);
    endtask

    task automatic t_top_carry();       // R6
        apply("R6", 32'h8000_0000, 32'h8000_0000, 1'b0, 33'h1_0000_0000);
        apply("R6", 32'hF000_0000, 32'h1000_0000, 1'b0, 33'h1_0000_0000);
    endtask

    task automatic t_cross();           // R8
        apply("R8", 32'h0000_000F, 32'h1, 1'b0, 33'h0_0000_0010);
        apply("R8", 32'h0FFF_FFFF, 32'h1, 1'b0, 33'h0_1000_0000);
        apply("R8", 32'h0000_00F8, 32'h0000_0008, 1'b0, 33'h0_0000_0100);
    endtask

    task automatic t_random();          // R1
        for (int n = 0; n < 4000; n++) begin
            logic [W-1:0] x, y;
            logic c;
            x = $urandom();
            y = $urandom();
            c = 1'($urandom());
            if (n % 4 == 0) y = ~x;
            apply("R1", x, y, c, model(x, y, c));
        end
    endtask

    task automatic t_exhaustive_narrow(); // R1
        for (int c = 0; c < 2; c++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y++) begin
                    na = NW'(x); nb = NW'(y); nci = 1'(c);
                    #1;
                    check("R1 narrow", {{(W-NW){1'b0}}, nco, ns}, 33'(x + y + c));
                end
            end
        end
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        na = '0; nb = '0; nci = 1'b0;
        repeat (2) @(posedge clk);
        t_zero();
        t_cin_only();
        t_gp();
        t_ripple();
        t_skip();
        t_top_carry();
        t_cross();
        t_random();
        t_exhaustive_narrow();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule